// File: doc/BRIEF.md
# Fixed-Gain Three-Phase Grid Phase Tracker

This block follows the phase angle and the angular frequency of a three-phase grid voltage. It works on one sample at a time. Each accepted sample carries three signed phase voltages. The block first maps them onto two orthogonal stationary axes. It then predicts the next angle from its stored state and rotates the stationary pair by that predicted angle. The quadrature result of the rotation is the phase error. A constant two-element gain vector scales this error, and the block adds the scaled values to the predicted angle and to the predicted frequency. The gains are never recomputed. Because the input is taken to be 1 p.u., the error is not normalised by amplitude.

Samples enter on a valid/ready stream and results leave on another. The block holds one result at a time. A sample is taken when `smp_valid` and `smp_ready` are both high. Its angle and frequency estimate appear in the following cycle with `est_valid` high. They stay there, unchanged, until the consumer raises `est_ready`. While a result is waiting and `est_ready` is low, `smp_ready` is low and no new sample can enter. The consumer can therefore stall the producer for as long as it needs to.

The angle is stored as an unsigned turn fraction: 2^32 stands for 2π, so the angle wraps on its own. The frequency is stored as the angle advance per sample period (100 µs), in the same units. The nominal 50 Hz is therefore 21474836.

Top module: `grid_sync_est`

## Requirements
- R1: After a synchronous reset, `est_angle` is 0, `est_freq` is 21474836, `est_valid` is 0 and `smp_ready` is 1.
- R2: A sample is accepted in a cycle where `smp_valid` and `smp_ready` are both high. In the next cycle `est_valid` is 1. `smp_ready` equals (not `est_valid`) or `est_ready`. `est_valid` falls after a cycle with `est_ready` high and no accepted sample.
- R3: While `est_valid` is 1 and `est_ready` is 0, `smp_ready` is 0. In that state `est_angle`, `est_freq` and `est_valid` hold their values, and an offered sample is ignored.
- R4: The stationary pair is computed as follows. alpha = sat16(((2a−b−c)·21845) >>> 16). beta = sat16(((b−c)·37837) >>> 16). Here sat16 clamps to [−32768, 32767].
- R5: The predicted angle P equals the stored angle plus the stored frequency, modulo 2^32. The table index is i = P[31:22]. The sine value is S(i) = round-half-away(16384·sin(2π·i/1024)), and the cosine value is S((i+256) mod 1024). The error is vq = sat16((beta·cos − alpha·sin) >>> 14).
- R6: An accepted sample with zero voltages on all three phases gives vq = 0. The new angle is then the old angle plus the old frequency, modulo 2^32, and the frequency is unchanged.
- R7: On each accepted sample, the new angle is (P + ((vq·188833) >>> 8)) mod 2^32. The new frequency, before clamping, is the old frequency + ((vq·1669) >>> 8).
- R8: The stored frequency is clamped to the range [17179869, 25769804], which is 40 Hz to 60 Hz.
- R9: Outputs change only in the cycle after an accepted sample.
- R10: A balanced input at 0.98 p.u. settles to within 0.2 Hz of the input frequency. This holds at 50 Hz, after an 80° phase jump, and after a step to 55 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample can be taken |
| ph_a | input | 16 | Phase A voltage, signed, 16384 = 1 p.u. |
| ph_b | input | 16 | Phase B voltage, signed |
| ph_c | input | 16 | Phase C voltage, signed |
| est_valid | output | 1 | Estimate held for the consumer |
| est_ready | input | 1 | Consumer takes the estimate |
| est_angle | output | 32 | Corrected angle, 2^32 = 2π |
| est_freq | output | 32 | Corrected frequency, signed, angle advance per sample |

## Verification
The frequency clamp is the hardest situation to reach from the ports. A locked loop keeps its error near zero, so a plain sine input never pushes the state to its limits. To get there, the bench drives each sample 90° ahead of, or behind, the angle its own model predicts. This holds the error near full scale for long enough to drive the frequency to each bound. A second input set saturates the stationary transform. Both cases are compared with the model on every clock, while the consumer applies random back-pressure.

// File: rtl/gsync_pkg.sv
package gsync_pkg;

  typedef enum logic {
    OUT_EMPTY = 1'b0,
    OUT_HELD  = 1'b1
  } out_state_e;

  // clamp a wide signed value into a w-bit signed range
  function automatic logic signed [63:0] sat_w(input logic signed [63:0] x, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

endpackage

// File: rtl/gsync_clarke.sv
module gsync_clarke import gsync_pkg::*; #(
  parameter int VW = 16
) (
  input  logic signed [VW-1:0] a,
  input  logic signed [VW-1:0] b,
  input  logic signed [VW-1:0] c,
  output logic signed [VW-1:0] alpha,
  output logic signed [VW-1:0] beta
);
  localparam int CSH = 16;
  // round(2^16/3) and round(2^16/sqrt(3))
  localparam logic signed [63:0] K_THIRD = 64'sd21845;
  localparam logic signed [63:0] K_ISQ3  = 64'sd37837;

  logic signed [63:0] sum3, diff;

  always_comb begin
    sum3  = 64'(a) * 64'sd2 - 64'(b) - 64'(c);
    diff  = 64'(b) - 64'(c);
    alpha = VW'(sat_w((sum3 * K_THIRD) >>> CSH, VW));
    beta  = VW'(sat_w((diff * K_ISQ3) >>> CSH, VW));
  end
endmodule

// File: rtl/gsync_sincos.sv
module gsync_sincos #(
  parameter int AW = 32,
  parameter int VW = 16,
  parameter int LB = 10
) (
  input  logic [AW-1:0]        ang,
  output logic signed [VW-1:0] sin_o,
  output logic signed [VW-1:0] cos_o
);
  localparam int  QB  = LB - 2;
  localparam int  QN  = 2 ** QB;
  localparam int  AMP = 2 ** (VW - 2);
  localparam real PI  = 3.14159265358979323846;
  localparam logic [QB:0] QN_V = (QB + 1)'(QN);

  logic signed [VW-1:0] qtab [0:QN];

  initial begin
    for (int i = 0; i <= QN; i++) begin
      qtab[i] = VW'($rtoi($floor(real'(AMP) * $sin(PI * real'(i) / (2.0 * real'(QN))) + 0.5)));
    end
  end

  function automatic logic signed [VW-1:0] fetch(input logic [LB-1:0] i);
    logic [QB:0]          ix;
    logic signed [VW-1:0] m;
    if (i[LB-2]) ix = QN_V - {1'b0, i[QB-1:0]};
    else         ix = {1'b0, i[QB-1:0]};
    m = qtab[ix];
    return i[LB-1] ? -m : m;
  endfunction

  logic signed [VW-1:0] vals [2];

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic [LB-1:0] idx;
    assign idx     = ang[AW-1 -: LB] + LB'(k * QN);
    assign vals[k] = fetch(idx);
  end

  assign sin_o = vals[0];
  assign cos_o = vals[1];
endmodule

// File: rtl/gsync_core.sv
module gsync_core import gsync_pkg::*; #(
  parameter int AW       = 32,
  parameter int VW       = 16,
  parameter int GS       = 8,
  parameter int GAIN_ANG = 188833,
  parameter int GAIN_FRQ = 1669,
  parameter int FREQ_NOM = 21474836,
  parameter int FREQ_LO  = 17179869,
  parameter int FREQ_HI  = 25769804
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic signed [VW-1:0] alpha,
  input  logic signed [VW-1:0] beta,
  input  logic signed [VW-1:0] sin_v,
  input  logic signed [VW-1:0] cos_v,
  output logic [AW-1:0]        pred_ang,
  output logic [AW-1:0]        ang,
  output logic signed [AW-1:0] frq
);
  logic [AW-1:0]        ang_q, ang_n;
  logic signed [AW-1:0] frq_q, frq_n;
  logic signed [VW-1:0] vq;
  logic signed [63:0]   mix, ca, fs;

  assign pred_ang = ang_q + frq_q;

  always_comb begin
    mix   = 64'(beta) * 64'(cos_v) - 64'(alpha) * 64'(sin_v);
    vq    = VW'(sat_w(mix >>> (VW - 2), VW));
    ca    = (64'(vq) * 64'(GAIN_ANG)) >>> GS;
    ang_n = pred_ang + ca[AW-1:0];
    fs    = 64'(frq_q) + ((64'(vq) * 64'(GAIN_FRQ)) >>> GS);
    if (fs > 64'(FREQ_HI))      frq_n = AW'(FREQ_HI);
    else if (fs < 64'(FREQ_LO)) frq_n = AW'(FREQ_LO);
    else                        frq_n = AW'(fs);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ang_q <= '0;
      frq_q <= AW'(FREQ_NOM);
    end else if (upd) begin
      ang_q <= ang_n;
      frq_q <= frq_n;
    end
  end

  assign ang = ang_q;
  assign frq = frq_q;
endmodule

// File: rtl/grid_sync_est.sv
module grid_sync_est import gsync_pkg::*; #(
  parameter int VW         = 16,
  parameter int AW         = 32,
  parameter int LUT_BITS   = 10,
  parameter int GAIN_SHIFT = 8,
  parameter int GAIN_ANG   = 188833,
  parameter int GAIN_FRQ   = 1669,
  parameter int FREQ_NOM   = 21474836,
  parameter int FREQ_LO    = 17179869,
  parameter int FREQ_HI    = 25769804
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic signed [VW-1:0] ph_a,
  input  logic signed [VW-1:0] ph_b,
  input  logic signed [VW-1:0] ph_c,
  output logic                 est_valid,
  input  logic                 est_ready,
  output logic [AW-1:0]        est_angle,
  output logic signed [AW-1:0] est_freq
);
  out_state_e           ost;
  logic                 take;
  logic signed [VW-1:0] alpha, beta, sin_v, cos_v;
  logic [AW-1:0]        pred_ang;

  assign smp_ready = (ost == OUT_EMPTY) || est_ready;
  assign take      = smp_valid && smp_ready;
  assign est_valid = (ost == OUT_HELD);

  always_ff @(posedge clk) begin
    if (rst)            ost <= OUT_EMPTY;
    else if (take)      ost <= OUT_HELD;
    else if (est_ready) ost <= OUT_EMPTY;
  end

  gsync_clarke #(.VW(VW)) u_clarke (
    .a(ph_a), .b(ph_b), .c(ph_c), .alpha(alpha), .beta(beta)
  );

  gsync_sincos #(.AW(AW), .VW(VW), .LB(LUT_BITS)) u_trig (
    .ang(pred_ang), .sin_o(sin_v), .cos_o(cos_v)
  );

  gsync_core #(
    .AW(AW), .VW(VW), .GS(GAIN_SHIFT), .GAIN_ANG(GAIN_ANG), .GAIN_FRQ(GAIN_FRQ),
    .FREQ_NOM(FREQ_NOM), .FREQ_LO(FREQ_LO), .FREQ_HI(FREQ_HI)
  ) u_core (
    .clk(clk), .rst(rst), .upd(take), .alpha(alpha), .beta(beta),
    .sin_v(sin_v), .cos_v(cos_v), .pred_ang(pred_ang),
    .ang(est_angle), .frq(est_freq)
  );
endmodule

// File: rtl/gsync_chk.sv
module gsync_chk #(
  parameter int AW      = 32,
  parameter int FREQ_LO = 17179869,
  parameter int FREQ_HI = 25769804
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_valid,
  input logic                 smp_ready,
  input logic                 est_valid,
  input logic                 est_ready,
  input logic [AW-1:0]        est_angle,
  input logic signed [AW-1:0] est_freq
);
  // R2
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_ready) |=> est_valid);
  // R2
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (est_valid && est_ready && !smp_valid) |=> !est_valid);
  // R3
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (est_valid && !est_ready) |-> !smp_ready);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (est_valid && !est_ready) |=> (est_valid && $stable(est_angle) && $stable(est_freq)));
  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && smp_ready) |=> ($stable(est_angle) && $stable(est_freq)));
  // R8
  freq_range_chk: assert property (@(posedge clk) disable iff (rst)
    (est_freq >= FREQ_LO) && (est_freq <= FREQ_HI));
endmodule

bind grid_sync_est gsync_chk #(.AW(AW), .FREQ_LO(FREQ_LO), .FREQ_HI(FREQ_HI)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .est_valid(est_valid), .est_ready(est_ready),
  .est_angle(est_angle), .est_freq(est_freq)
);

// File: tb/grid_sync_est_tb.sv
module grid_sync_est_tb;
  localparam int     CLK_PERIOD = 10;
  localparam longint NOM  = 21474836;
  localparam longint FLO  = 17179869;
  localparam longint FHI  = 25769804;
  localparam longint MASK = 64'h0000_0000_FFFF_FFFF;
  localparam real    PI   = 3.14159265358979323846;

  logic clk = 0, rst = 1, smp_valid = 0, est_ready = 1;
  logic signed [15:0] ph_a = 0, ph_b = 0, ph_c = 0;
  logic smp_ready, est_valid;
  logic [31:0] est_angle;
  logic signed [31:0] est_freq;

  grid_sync_est u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .est_valid(est_valid),
    .est_ready(est_ready), .est_angle(est_angle), .est_freq(est_freq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int     checks = 0, errors = 0;
  bit     done = 0;
  string  tag = "R1";
  longint m_ang = 0, m_frq = NOM;
  bit     m_val = 0;
  real    th_in = 0.0, f_in = 50.0, amp = 0.98 * 16384.0;

  function automatic longint rnd(real x);
    return x >= 0.0 ? longint'($rtoi(x + 0.5)) : -longint'($rtoi(-x + 0.5));
  endfunction

  function automatic longint lut(longint idx);
    return rnd(16384.0 * $sin(2.0 * PI * real'(idx) / 1024.0));
  endfunction

  function automatic longint sat16(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic model_step(longint a, longint b, longint c);
    longint al, be, pa, idx, vq, f;
    al  = sat16(((2*a - b - c) * 21845) >>> 16);
    be  = sat16(((b - c) * 37837) >>> 16);
    pa  = (m_ang + m_frq) & MASK;
    idx = pa >> 22;
    vq  = sat16((be * lut((idx + 256) % 1024) - al * lut(idx)) >>> 14);
    m_ang = (pa + ((vq * 188833) >>> 8)) & MASK;
    f = m_frq + ((vq * 1669) >>> 8);
    if (f > FHI) f = FHI;
    if (f < FLO) f = FLO;
    m_frq = f;
  endtask

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_ports();
    check(est_valid == m_val, "est_valid", est_valid, m_val);
    check(smp_ready == (!m_val || est_ready), "smp_ready", smp_ready, !m_val || est_ready);
    check(longint'(est_angle) == m_ang, "est_angle", longint'(est_angle), m_ang);
    check(longint'(est_freq) == m_frq, "est_freq", longint'(est_freq), m_frq);
  endtask

  task automatic cyc(bit v, longint a, longint b, longint c, bit rdy, output bit acc);
    cmp_ports();
    smp_valid = v; ph_a = 16'(a); ph_b = 16'(b); ph_c = 16'(c); est_ready = rdy;
    acc = v && (!m_val || rdy);
    if (acc) begin
      model_step(a, b, c);
      m_val = 1;
    end else if (rdy) m_val = 0;
    @(negedge clk);
  endtask

  task automatic send(longint a, longint b, longint c);
    bit acc;
    int gap = $urandom % 3;
    for (int i = 0; i < gap; i++) cyc(0, 0, 0, 0, ($urandom % 4) != 0, acc);
    acc = 0;
    while (!acc) cyc(1, a, b, c, ($urandom % 4) != 0, acc);
  endtask

  task automatic send_angle(real th);
    send(rnd(amp * $cos(th)), rnd(amp * $cos(th - 2.0*PI/3.0)), rnd(amp * $cos(th + 2.0*PI/3.0)));
  endtask

  task automatic run_grid(int n);
    for (int i = 0; i < n; i++) begin
      send_angle(th_in);
      th_in = th_in + 2.0 * PI * f_in * 1.0e-4;
      if (th_in > 2.0 * PI) th_in = th_in - 2.0 * PI;
    end
  endtask

  task automatic track(real off, int n);
    for (int i = 0; i < n; i++)
      send_angle(real'((m_ang + m_frq) & MASK) / 4294967296.0 * 2.0 * PI + off);
  endtask

  function automatic longint hz(real f);
    return rnd(f * 4294967296.0 / 10000.0);
  endfunction

  function automatic longint absl(longint x);
    return x < 0 ? -x : x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    longint oa, of;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    tag = "R1";
    check(est_angle == 0, "reset angle", longint'(est_angle), 0);
    check(longint'(est_freq) == NOM, "reset freq", longint'(est_freq), NOM);
    check(est_valid == 0, "reset valid", est_valid, 0);
    check(smp_ready == 1, "reset ready", smp_ready, 1);

    // R6 zero input: free run with wrap
    tag = "R6";
    for (int i = 0; i < 250; i++) begin
      oa = longint'(est_angle); of = longint'(est_freq);
      send(0, 0, 0);
      check(longint'(est_angle) == ((oa + of) & MASK), "free-run angle", longint'(est_angle), (oa + of) & MASK);
      check(longint'(est_freq) == of, "free-run freq", longint'(est_freq), of);
    end

    // R2 handshake timing
    tag = "R2";
    cyc(0, 0, 0, 0, 1, acc);
    cyc(1, 100, -50, -50, 1, acc);
    check(est_valid == 1, "valid after accept", est_valid, 1);
    cyc(0, 0, 0, 0, 1, acc);
    check(est_valid == 0, "valid drop", est_valid, 0);

    // R3 back-pressure hold
    tag = "R3";
    cyc(1, 300, -150, -150, 0, acc);
    oa = longint'(est_angle); of = longint'(est_freq);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 9000, -9000, 0, 0, acc);
      check(smp_ready == 0, "stall ready", smp_ready, 0);
      check(est_valid == 1, "stall valid", est_valid, 1);
      check(longint'(est_angle) == oa, "stall angle", longint'(est_angle), oa);
      check(longint'(est_freq) == of, "stall freq", longint'(est_freq), of);
    end
    cyc(0, 0, 0, 0, 1, acc);

    // R5 lock at nominal
    tag = "R5";
    th_in = real'(est_angle) / 4294967296.0 * 2.0 * PI;
    f_in = 50.0;
    run_grid(2000);
    tag = "R10";
    check(absl(longint'(est_freq) - hz(50.0)) < hz(0.2), "lock 50Hz", longint'(est_freq), hz(50.0));

    // R7 gain step with known error
    tag = "R7";
    oa = longint'(est_angle); of = longint'(est_freq);
    track(PI / 2.0, 1);
    check(longint'(est_freq) - of > 103000 && longint'(est_freq) - of < 106000,
          "freq step", longint'(est_freq) - of, 104677);
    check(((longint'(est_angle) - oa - of) & MASK) > 11600000 && ((longint'(est_angle) - oa - of) & MASK) < 12000000,
          "angle step", (longint'(est_angle) - oa - of) & MASK, 11843000);
    th_in = real'(est_angle) / 4294967296.0 * 2.0 * PI;
    run_grid(500);
    th_in = th_in + 80.0 * PI / 180.0;
    run_grid(1500);
    tag = "R10";
    check(absl(longint'(est_freq) - hz(50.0)) < hz(0.2), "relock after jump", longint'(est_freq), hz(50.0));

    // R10 frequency step
    tag = "R5";
    f_in = 55.0;
    run_grid(3000);
    tag = "R10";
    check(absl(longint'(est_freq) - hz(55.0)) < hz(0.2), "lock 55Hz", longint'(est_freq), hz(55.0));

    // R8 clamps
    tag = "R8";
    track(PI / 2.0, 80);
    check(longint'(est_freq) == FHI, "upper clamp", longint'(est_freq), FHI);
    track(-PI / 2.0, 150);
    check(longint'(est_freq) == FLO, "lower clamp", longint'(est_freq), FLO);

    // R4 transform saturation
    tag = "R4";
    for (int i = 0; i < 6; i++) begin
      send(32767, -32768, -32768);
      send(0, 32767, -32768);
      send(-32768, 32767, 32767);
    end

    tag = "R5";
    f_in = 50.0;
    run_grid(2500);
    tag = "R10";
    check(absl(longint'(est_freq) - hz(50.0)) < hz(0.2), "recover from clamp", longint'(est_freq), hz(50.0));
    cmp_ports();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule